// File: doc/BRIEF.md
# Hysteretic Burst Gate for Motion Measurements

This block sits between a motion-measurement source and a trajectory predictor. It decides whether the incoming activity is dense and sustained enough to be trusted. Every clock it samples a one-bit qualifying-event flag. It keeps the flags of the most recent `WIN` cycles in a sliding window, along with a running count of the set flags.

The gate has two thresholds. It opens as soon as the window count, including the event in the current cycle, reaches an opening threshold. Once open, it stays open while at least the lower holding number of events remain in the window. A burst that is too short never opens the gate. Noise near the threshold cannot make the gate toggle every cycle.

While the gate is open, measurement beats pass straight through a valid/ready handshake to the predictor. While it is closed, beats are accepted and thrown away, so the source never stalls. A status output reports the gate state.

Top module: `burst_gate`

## Requirements
- R1: After `rst_n` is asserted, `gate_open` and `out_valid` go low at once, and the window is empty. After reset is released, the gate stays closed until a fresh set of events opens it.
- R2: An event sampled at clock edge k counts in the window for exactly `WIN` (16) edges, k through k+15. The count saturates at `WIN` and never overflows, however long a run of events lasts.
- R3: While the gate is closed, `gate_open` rises at the edge where the window count, including the event of that edge, reaches `TH_OPEN` (3).
- R4: While the gate is open, it remains open at every edge where the window count is at least `TH_CLOSE` (1), even when that count is below `TH_OPEN`.
- R5: The open gate closes at the edge where the window count falls to zero, which is 16 edges after the last event.
- R6: While the gate is closed, `out_valid` is 0 and `in_ready` is 1 regardless of `out_ready`, so every beat offered is dropped.
- R7: While the gate is open, `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`.
- R8: A closed gate does not open while the window count is below `TH_OPEN`. This holds even right after the gate has closed, when one or two new events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| evt_i | input | 1 | Qualifying event flag for this cycle |
| in_valid | input | 1 | Upstream measurement beat valid |
| in_data | input | DW | Upstream measurement beat payload |
| in_ready | output | 1 | Beat accepted (forwarded or dropped) |
| out_valid | output | 1 | Beat offered to the predictor |
| out_data | output | DW | Beat payload to the predictor |
| out_ready | input | 1 | Predictor can take the beat |
| gate_open | output | 1 | Gate state |

## Verification
The gate state is registered, so `gate_open` takes its new value in the same clock edge that samples the event. The bench therefore sets `evt_i` away from the edge and reads `gate_open` shortly after the next rising edge. The closing edge comes exactly 16 edges after the last event, and the bench counts out that window edge by edge, checking one edge before the closing edge as well as the closing edge itself. The handshake outputs are combinational from the registered state and the current inputs. Handshake checks are therefore made in the same cycle, a moment after the inputs change, with no clock edge in between. Assertion of reset takes effect without a clock and is checked that way.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_PASS = 1'b1
  } gate_state_e;
endpackage

// File: rtl/burst_window.sv
module burst_window #(
  parameter int WIN = 16,
  parameter int CW  = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  output logic [CW-1:0] cnt_now_o
);
  logic [WIN-1:0] win_q, win_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           en;

  // slide the window one slot; count = old count + new flag - expiring flag
  always_comb begin
    win_d = {win_q[WIN-2:0], evt_i};
    cnt_d = cnt_q + CW'(evt_i) - CW'(win_q[WIN-1]);
    en    = evt_i | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_now_o = cnt_d;

  a_r2_count_tracks_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(win_q)));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WIN));
endmodule

// File: rtl/burst_hyst.sv
module burst_hyst
  import burst_gate_pkg::*;
#(
  parameter int WIN      = 16,
  parameter int TH_OPEN  = 3,
  parameter int TH_CLOSE = 1,
  parameter int CW       = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  output logic          open_o
);
  localparam logic [CW-1:0] OPEN_C  = CW'(TH_OPEN);
  localparam logic [CW-1:0] CLOSE_C = CW'(TH_CLOSE);

  gate_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GATE_SHUT: if (cnt_i >= OPEN_C)  st_d = GATE_PASS;
      GATE_PASS: if (cnt_i <  CLOSE_C) st_d = GATE_SHUT;
      default:   st_d = GATE_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GATE_SHUT;
    else        st_q <= st_d;
  end

  assign open_o = (st_q == GATE_PASS);

  a_r3_open_needs_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(cnt_i) >= OPEN_C);
  a_r4_hold_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && cnt_i >= CLOSE_C) |=> open_o);
  a_r5_close_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && cnt_i == '0) |=> !open_o);
  a_r8_stay_shut_below: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_o && cnt_i < OPEN_C) |=> !open_o);
endmodule

// File: rtl/burst_pass.sv
module burst_pass #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  always_comb begin
    out_valid = in_valid & open_i;
    out_data  = in_data;
    in_ready  = open_i ? out_ready : 1'b1;
  end

  a_r6_block_when_shut: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |-> (!out_valid && in_ready));
  a_r7_follow_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |-> (out_valid == in_valid && in_ready == out_ready));
endmodule

// File: rtl/burst_gate.sv
module burst_gate #(
  parameter int WIN      = 16,
  parameter int TH_OPEN  = 3,
  parameter int TH_CLOSE = 1,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          gate_open
);
  localparam int CW = $clog2(WIN + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [CW-1:0] cnt_now;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  burst_window #(.WIN(WIN), .CW(CW)) u_window (
    .clk(clk), .rst_n(rst_int_n), .evt_i(evt_i), .cnt_now_o(cnt_now)
  );

  burst_hyst #(.WIN(WIN), .TH_OPEN(TH_OPEN), .TH_CLOSE(TH_CLOSE), .CW(CW)) u_hyst (
    .clk(clk), .rst_n(rst_int_n), .cnt_i(cnt_now), .open_o(gate_open)
  );

  burst_pass #(.DW(DW)) u_pass (
    .clk(clk), .rst_n(rst_int_n), .open_i(gate_open),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  a_r1_reset_closes: assert property (@(posedge clk)
    !rst_int_n |-> (!gate_open && !out_valid));
endmodule

// File: tb/burst_gate_bench.sv
`timescale 1ns/1ps
module burst_gate_bench;
  localparam int DW = 32;
  localparam int N  = 32;
  // event per cycle, and expected gate state after that cycle's edge
  localparam logic [0:N-1] EVT = 32'b1010_1000_0000_0000_0000_0111_0000_0000;
  localparam logic [0:N-1] EXP = 32'b0000_1111_1111_1111_1111_0001_1111_1111;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          evt_i;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_ready;
  logic          gate_open;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  burst_gate #(.DW(DW)) u_burst_gate (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .gate_open(gate_open)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic e);
    evt_i = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_i = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    #12;
    chk(DW'(gate_open), 0, "R1 gate closed in reset");
    chk(DW'(out_valid), 0, "R1 no output in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b0);
    chk(DW'(gate_open), 0, "R1 closed after release");

    // vector table: R2 R3 R4 R5 R7 R8
    in_valid = 1'b1;
    for (int i = 0; i < N; i++) begin
      in_data = DW'(32'hA500 + i);
      tick(EVT[i]);
      chk(DW'(gate_open), DW'(EXP[i]), $sformatf("R3/R4/R5/R8 gate at step %0d", i));
      chk(DW'(out_valid), DW'(EXP[i]), $sformatf("R6/R7 out_valid at step %0d", i));
      chk(DW'(in_ready), 1, $sformatf("R6/R7 in_ready at step %0d", i));
      if (EXP[i]) chk(out_data, DW'(32'hA500 + i), $sformatf("R7 data at step %0d", i));
    end

    // R7 handshake while open
    out_ready = 1'b0; #1;
    chk(DW'(in_ready), 0, "R7 backpressure passes through");
    chk(DW'(out_valid), 1, "R7 valid passes through");
    in_valid = 1'b0; #1;
    chk(DW'(out_valid), 0, "R7 idle passes through");
    out_ready = 1'b1;

    // R5: last events at steps 21..23; closes 16 edges after step 23
    for (int i = 0; i < 7; i++) tick(1'b0);
    chk(DW'(gate_open), 1, "R4 open one edge before expiry");
    tick(1'b0);
    chk(DW'(gate_open), 0, "R5 closes when window empties");

    // R6 drop while closed, even under backpressure
    in_valid = 1'b1; out_ready = 1'b0; #1;
    chk(DW'(in_ready), 1, "R6 dropped beat accepted");
    chk(DW'(out_valid), 0, "R6 no beat forwarded");
    in_valid = 1'b0; out_ready = 1'b1;

    // R2: long run saturates, closes exactly 16 edges after the last event
    for (int i = 0; i < 20; i++) begin
      tick(1'b1);
      if (i == 1) chk(DW'(gate_open), 0, "R8 two events keep gate shut");
      if (i == 2) chk(DW'(gate_open), 1, "R3 opens on third event");
    end
    for (int i = 0; i < 15; i++) tick(1'b0);
    chk(DW'(gate_open), 1, "R2 saturated window still open at edge 15");
    tick(1'b0);
    chk(DW'(gate_open), 0, "R2 window empties at edge 16");

    // R1: asynchronous reset while open clears the window
    tick(1'b1); tick(1'b1); tick(1'b1);
    chk(DW'(gate_open), 1, "R3 reopened before reset");
    in_valid = 1'b1;
    rst_n = 1'b0; #1;
    chk(DW'(gate_open), 0, "R1 async reset closes gate");
    chk(DW'(out_valid), 0, "R1 async reset blocks output");
    evt_i = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b0);
    chk(DW'(gate_open), 0, "R1 window cleared by reset");
    tick(1'b1); tick(1'b1);
    chk(DW'(gate_open), 0, "R1 fresh events needed after reset");
    tick(1'b1);
    chk(DW'(gate_open), 1, "R3 opens after fresh events");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule